// File: doc/BRIEF.md
# Interlocked Link Training Sequencer

This block steps one lane adapter through two training sub-states in a fixed order. In each sub-state it tells the transmitter which ordered-set type to send. It tallies the complete sets that were sent and the run of matching sets that arrived from the far end. It moves on only when both tallies have met their thresholds. A larger transmit threshold makes sure the partner has seen enough of this end's pattern. A smaller consecutive-receive threshold shows that the partner is sending the pattern this end expects. Because each end waits for both conditions, the two ends of the link stay in step every time training starts.

The sub-states are IDLE (code 0), PHASE1 (code 1), PHASE2 (code 2), DONE (code 3) and TIMEOUT (code 4). The transitions are:
- IDLE→PHASE1 when training is enabled.
- PHASE1→PHASE2 and PHASE2→DONE when both conditions hold.
- PHASE1 or PHASE2→TIMEOUT when the block has waited too long for the receive condition after the transmit count was met.
- TIMEOUT→PHASE1 to restart training.
- Any state→IDLE when training is disabled.

Ordered-set type codes are 0 (none), 1 (phase-1 set), 2 (phase-2 set) and 3 (other). Serialization, symbol alignment and scrambling are handled elsewhere.

Top module: `link_train_seq`

## Requirements
- R1: The transmit select output is 1 in PHASE1, 2 in PHASE2 and 0 in IDLE, DONE and TIMEOUT.
- R2: From IDLE with the training enable high, the stage output becomes PHASE1 (code 1) after the next clock edge.
- R3: A phase advances only when at least TX_NEED (default 4) sent strobes and the latched receive condition are both present. Either one alone never advances the phase. The advance takes effect one cycle after the last condition is registered.
- R4: The receive condition is RX_NEED (default 2) consecutive received strobes whose type equals the current transmit select. A received strobe of any other type resets the run to zero.
- R5: Once met, the receive condition stays latched for the rest of the phase. Sets received before the transmit count is reached still count toward advancement.
- R6: On every phase entry, the sent tally, the receive run and the receive latch are cleared. Progress made in PHASE1 does not count in PHASE2.
- R7: Completing PHASE2 enters DONE. trained_o is high only in DONE and stays high while the enable stays high.
- R8: After the transmit count is met, if the receive condition is still missing for TMO_CYC cycles, the block enters TIMEOUT. timeout_o is high there for exactly one cycle, and then training restarts in PHASE1.
- R9: A low training enable sends the block to IDLE at the next clock edge from any state.
- R10: While reset is asserted, the stage is IDLE and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_en_i | input | 1 | Training enable |
| os_sent_i | input | 1 | One complete ordered set was transmitted this cycle |
| os_rcvd_i | input | 1 | One ordered set was received from the partner this cycle |
| os_rcvd_type_i | input | 2 | Type code of the received ordered set |
| stage_o | output | 3 | Current sub-state code |
| tx_os_sel_o | output | 2 | Ordered-set type the transmitter must send |
| trained_o | output | 1 | Training completed |
| timeout_o | output | 1 | One-cycle pulse when the receive wait expires |

## Verification
The checker watches several properties on every cycle:
- A disabled enable always leads to IDLE.
- IDLE always starts PHASE1.
- DONE holds while enabled.
- Each timeout pulse is followed by PHASE1.
- Every phase exit was preceded by at least TX_NEED sent strobes and RX_NEED matching receptions, counted independently of the design.

The bench scenarios cover the behaviours that depend on history:
- A receive run broken by a wrong type.
- A receive condition met before the transmit count.
- Progress that must not carry across a phase entry.
- The exact cycle at which the wait timer expires.

A cycle-accurate bench model compares every output on each cycle under random stimulus.

// File: rtl/lt_pkg.sv
package lt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PH1  = 3'd1,
        ST_PH2  = 3'd2,
        ST_DONE = 3'd3,
        ST_TMO  = 3'd4
    } lt_state_e;

    localparam logic [1:0] OS_NONE = 2'd0;
    localparam logic [1:0] OS_PH1  = 2'd1;
    localparam logic [1:0] OS_PH2  = 2'd2;

endpackage

// File: rtl/lt_tx_tally.sv
module lt_tx_tally #(
    parameter int unsigned TX_NEED = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic cnt_en_i,
    input  logic sent_i,
    output logic full_o
);
    localparam int unsigned W = $clog2(TX_NEED + 1);

    logic [W-1:0] cnt_q;

    assign full_o = (cnt_q == W'(TX_NEED));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (cnt_en_i && sent_i && !full_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lt_rx_run.sv
module lt_rx_run #(
    parameter int unsigned RX_NEED = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic cnt_en_i,
    input  logic match_i,
    input  logic miss_i,
    output logic ok_o
);
    localparam int unsigned W = $clog2(RX_NEED + 1);

    logic [W-1:0] run_q;
    logic         ok_q;
    logic         run_top;
    logic         run_hits;

    assign run_top  = (run_q == W'(RX_NEED));
    assign run_hits = (32'(run_q) + 32'd1 >= RX_NEED);
    assign ok_o     = ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            ok_q  <= 1'b0;
        end else if (clr_i) begin
            run_q <= '0;
            ok_q  <= 1'b0;
        end else if (cnt_en_i) begin
            if (match_i) begin
                if (!run_top) begin
                    run_q <= run_q + 1'b1;
                end
                if (run_hits) begin
                    ok_q <= 1'b1;
                end
            end else if (miss_i) begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
    parameter int unsigned TMO_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic wait_i,
    output logic expire_o
);
    localparam int unsigned W = (TMO_CYC < 2) ? 1 : $clog2(TMO_CYC);

    logic [W-1:0] cnt_q;

    assign expire_o = wait_i && (cnt_q == W'(TMO_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (wait_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
    import lt_pkg::*;
#(
    parameter int unsigned TX_NEED = 4,
    parameter int unsigned RX_NEED = 2,
    parameter int unsigned TMO_CYC = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       train_en_i,
    input  logic       os_sent_i,
    input  logic       os_rcvd_i,
    input  logic [1:0] os_rcvd_type_i,
    output logic [2:0] stage_o,
    output logic [1:0] tx_os_sel_o,
    output logic       trained_o,
    output logic       timeout_o
);
    lt_state_e  state_q;
    lt_state_e  state_nx;
    logic [1:0] sel;
    logic       in_phase;
    logic       seg_clr;
    logic       tx_full;
    logic       rx_ok;
    logic       rx_match;
    logic       rx_miss;
    logic       waiting;
    logic       tmo_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // next-state selection
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: state_nx = ST_PH1;
            ST_PH1: begin
                if (tx_full && rx_ok) begin
                    state_nx = ST_PH2;
                end else if (tmo_hit) begin
                    state_nx = ST_TMO;
                end
            end
            ST_PH2: begin
                if (tx_full && rx_ok) begin
                    state_nx = ST_DONE;
                end else if (tmo_hit) begin
                    state_nx = ST_TMO;
                end
            end
            ST_DONE: state_nx = ST_DONE;
            ST_TMO:  state_nx = ST_PH1;
            default: state_nx = ST_IDLE;
        endcase
        if (!train_en_i) begin
            state_nx = ST_IDLE;
        end
    end

    // outputs decoded from the state
    always_comb begin
        sel       = OS_NONE;
        trained_o = 1'b0;
        timeout_o = 1'b0;
        in_phase  = 1'b0;
        unique case (state_q)
            ST_PH1: begin
                sel      = OS_PH1;
                in_phase = 1'b1;
            end
            ST_PH2: begin
                sel      = OS_PH2;
                in_phase = 1'b1;
            end
            ST_DONE: trained_o = 1'b1;
            ST_TMO:  timeout_o = 1'b1;
            default: sel = OS_NONE;
        endcase
    end

    assign stage_o     = state_q;
    assign tx_os_sel_o = sel;
    assign seg_clr     = (state_nx != state_q);
    assign rx_match    = os_rcvd_i && (os_rcvd_type_i == sel);
    assign rx_miss     = os_rcvd_i && (os_rcvd_type_i != sel);
    assign waiting     = in_phase && tx_full && !rx_ok;

    lt_tx_tally #(.TX_NEED(TX_NEED)) u_tx_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (seg_clr),
        .cnt_en_i (in_phase),
        .sent_i   (os_sent_i),
        .full_o   (tx_full)
    );

    lt_rx_run #(.RX_NEED(RX_NEED)) u_rx_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (seg_clr),
        .cnt_en_i (in_phase),
        .match_i  (rx_match),
        .miss_i   (rx_miss),
        .ok_o     (rx_ok)
    );

    lt_wait_timer #(.TMO_CYC(TMO_CYC)) u_wait_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (seg_clr),
        .wait_i   (waiting),
        .expire_o (tmo_hit)
    );
endmodule

// File: rtl/lt_seq_chk.sv
module lt_seq_chk
    import lt_pkg::*;
#(
    parameter int unsigned TX_NEED = 4,
    parameter int unsigned RX_NEED = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       train_en_i,
    input logic       os_sent_i,
    input logic       os_rcvd_i,
    input logic [1:0] os_rcvd_type_i,
    input logic [2:0] stage_o,
    input logic [1:0] tx_os_sel_o,
    input logic       trained_o,
    input logic       timeout_o
);
    logic [2:0] prev_q;
    logic [7:0] sent_seen_q;
    logic [7:0] rcvd_seen_q;
    logic       rx_hit;

    assign rx_hit = os_rcvd_i && (os_rcvd_type_i == tx_os_sel_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q      <= 3'd0;
            sent_seen_q <= 8'd0;
            rcvd_seen_q <= 8'd0;
        end else begin
            prev_q <= stage_o;
            if (stage_o != prev_q) begin
                sent_seen_q <= {7'd0, os_sent_i};
                rcvd_seen_q <= {7'd0, rx_hit};
            end else begin
                if (os_sent_i && sent_seen_q != 8'hFF) sent_seen_q <= sent_seen_q + 8'd1;
                if (rx_hit && rcvd_seen_q != 8'hFF)    rcvd_seen_q <= rcvd_seen_q + 8'd1;
            end
        end
    end

    // R2
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_o == ST_IDLE && train_en_i) |=> (stage_o == ST_PH1));

    // R3
    advance_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage_o == ST_PH2 && prev_q == ST_PH1) || (stage_o == ST_DONE && prev_q == ST_PH2))
        |-> (sent_seen_q >= TX_NEED));

    // R3
    advance_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stage_o == ST_PH2 && prev_q == ST_PH1) || (stage_o == ST_DONE && prev_q == ST_PH2))
        |-> (rcvd_seen_q >= RX_NEED));

    // R7
    trained_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trained_o && train_en_i) |=> trained_o);

    // R8
    timeout_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && train_en_i) |=> (stage_o == ST_PH1 && !timeout_o));

    // R8
    timeout_after_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_o == ST_TMO && prev_q != ST_TMO) |-> (sent_seen_q >= TX_NEED));

    // R9
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !train_en_i |=> (stage_o == ST_IDLE && !trained_o && !timeout_o));
endmodule

bind link_train_seq lt_seq_chk #(.TX_NEED(TX_NEED), .RX_NEED(RX_NEED)) u_seq_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .train_en_i     (train_en_i),
    .os_sent_i      (os_sent_i),
    .os_rcvd_i      (os_rcvd_i),
    .os_rcvd_type_i (os_rcvd_type_i),
    .stage_o        (stage_o),
    .tx_os_sel_o    (tx_os_sel_o),
    .trained_o      (trained_o),
    .timeout_o      (timeout_o)
);

// File: tb/link_train_seq_bench.sv
`timescale 1ns/1ps
module link_train_seq_bench;
    localparam int unsigned TXN = 4;
    localparam int unsigned RXN = 2;
    localparam int unsigned TMO = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       sent = 1'b0;
    logic       rv = 1'b0;
    logic [1:0] ty = 2'd0;
    logic [2:0] stage;
    logic [1:0] sel;
    logic       trained;
    logic       tmo;

    always #2 clk = ~clk;

    link_train_seq #(.TX_NEED(TXN), .RX_NEED(RXN), .TMO_CYC(TMO)) u_link_train_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .train_en_i     (en),
        .os_sent_i      (sent),
        .os_rcvd_i      (rv),
        .os_rcvd_type_i (ty),
        .stage_o        (stage),
        .tx_os_sel_o    (sel),
        .trained_o      (trained),
        .timeout_o      (tmo)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int m_st = 0;
    int m_tx = 0;
    int m_run = 0;
    int m_wait = 0;
    bit m_ok = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_sel(input int st);
        if (st == 1) return 1;
        if (st == 2) return 2;
        return 0;
    endfunction

    task automatic model_update(input bit e, input bit s, input bit r, input int t);
        int nst;
        nst = m_st;
        if (!e) nst = 0;
        else begin
            case (m_st)
                0: nst = 1;
                1, 2: begin
                    if (m_tx >= TXN && m_ok) nst = m_st + 1;
                    else if (m_tx >= TXN && !m_ok && m_wait == TMO - 1) nst = 4;
                end
                3: nst = 3;
                4: nst = 1;
                default: nst = 0;
            endcase
        end
        if (nst != m_st) begin
            m_tx = 0; m_run = 0; m_wait = 0; m_ok = 0;
        end else if (m_st == 1 || m_st == 2) begin
            if (m_tx >= TXN && !m_ok) m_wait++;
            if (s && m_tx < TXN) m_tx++;
            if (r) begin
                if (t == exp_sel(m_st)) begin
                    if (m_run + 1 >= RXN) m_ok = 1;
                    if (m_run < RXN) m_run++;
                end else begin
                    m_run = 0;
                end
            end
        end
        m_st = nst;
    endtask

    task automatic compare();
        chk(int'(stage) == m_st, "R3 stage vs model", int'(stage), m_st);
        chk(int'(sel) == exp_sel(m_st), "R1 tx select vs model", int'(sel), exp_sel(m_st));
        chk(trained == (m_st == 3), "R7 trained vs model", int'(trained), int'(m_st == 3));
        chk(tmo == (m_st == 4), "R8 timeout vs model", int'(tmo), int'(m_st == 4));
    endtask

    task automatic step(input bit e, input bit s, input bit r, input logic [1:0] t);
        en = e; sent = s; rv = r; ty = t;
        @(posedge clk);
        model_update(e, s, r, int'(t));
        @(negedge clk);
        compare();
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

    initial begin
        bit seen;
        void'($urandom(32'd20251));
        // R10 reset state
        repeat (3) @(negedge clk);
        chk(stage == 3'd0, "R10 stage in reset", int'(stage), 0);
        chk(sel == 2'd0 && !trained && !tmo, "R10 outputs in reset",
            int'({sel, trained, tmo}), 0);
        rst_n = 1'b1;
        step(0, 0, 0, 2'd0);

        // R2 start
        step(1, 0, 0, 2'd0);
        chk(stage == 3'd1, "R2 enter PHASE1", int'(stage), 1);
        chk(sel == 2'd1, "R1 PHASE1 select", int'(sel), 1);

        // R5 receive first, then transmit
        step(1, 0, 1, 2'd1);
        step(1, 0, 1, 2'd1);
        repeat (3) step(1, 1, 0, 2'd0);
        chk(stage == 3'd1, "R5 latched rx waits for tx", int'(stage), 1);
        step(1, 1, 0, 2'd0);
        chk(stage == 3'd1, "R3 no advance on count edge", int'(stage), 1);
        step(1, 0, 0, 2'd0);
        chk(stage == 3'd2, "R3 advance to PHASE2", int'(stage), 2);

        // R6 fresh counts in PHASE2
        repeat (3) step(1, 1, 0, 2'd0);
        step(1, 0, 1, 2'd2);
        step(1, 0, 1, 2'd2);
        repeat (3) step(1, 0, 0, 2'd0);
        chk(stage == 3'd2, "R6 counters cleared on entry", int'(stage), 2);
        step(1, 1, 0, 2'd0);
        step(1, 0, 0, 2'd0);
        chk(stage == 3'd3 && trained, "R7 DONE reached", int'(stage), 3);
        repeat (5) step(1, 0, 0, 2'd0);
        chk(trained == 1'b1, "R7 trained holds", int'(trained), 1);

        // R9 disable
        step(0, 0, 0, 2'd0);
        chk(stage == 3'd0 && !trained, "R9 back to IDLE", int'(stage), 0);

        // R4 broken run
        step(1, 0, 0, 2'd0);
        repeat (4) step(1, 1, 0, 2'd0);
        step(1, 0, 1, 2'd1);
        step(1, 0, 1, 2'd3);
        step(1, 0, 1, 2'd1);
        step(1, 0, 0, 2'd0);
        chk(stage == 3'd1, "R4 wrong type breaks run", int'(stage), 1);
        step(1, 0, 1, 2'd1);
        step(1, 0, 0, 2'd0);
        chk(stage == 3'd2, "R4 run completes", int'(stage), 2);

        // R3 receive alone is not enough
        step(0, 0, 0, 2'd0);
        step(1, 0, 0, 2'd0);
        repeat (5) step(1, 0, 1, 2'd1);
        repeat (5) step(1, 0, 0, 2'd0);
        chk(stage == 3'd1, "R3 rx alone no advance", int'(stage), 1);

        // R8 timeout
        step(0, 0, 0, 2'd0);
        step(1, 0, 0, 2'd0);
        repeat (4) step(1, 1, 0, 2'd0);
        seen = 0;
        for (int i = 0; i < int'(TMO) + 5 && !seen; i++) begin
            step(1, 0, 0, 2'd0);
            if (tmo) seen = 1;
        end
        chk(seen, "R8 timeout pulse seen", int'(seen), 1);
        step(1, 0, 0, 2'd0);
        chk(stage == 3'd1 && !tmo, "R8 restart in PHASE1", int'(stage), 1);

        // random stimulus
        for (int mode = 0; mode < 3; mode++) begin
            repeat (6000) begin
                bit e, s, r;
                logic [1:0] t;
                e = ($urandom % 300) != 0;
                s = ($urandom % 3) == 0;
                r = (mode == 2) ? (($urandom % 25) == 0) : (($urandom % 3) == 0);
                if (mode != 1 && ($urandom % 4) != 0) t = 2'(exp_sel(m_st));
                else t = 2'($urandom % 4);
                step(e, s, r, t);
            end
        end

        finished = 1;
        report();
    end
endmodule